// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block decides, for every incoming Ethernet frame, whether the frame is kept or dropped, judging only by its 48-bit destination address. The receive path hands it the destination bytes one per clock, in wire order, right after the start-of-frame delimiter. The block collects the six bytes and runs a CRC-32 over them as they arrive. It then resolves one decision from the active rules: exact match against the station address, two 64-entry hash tables (one for unicast destinations, one for group destinations), a broadcast reject option and a promiscuous override.

The decision comes with a valid strobe and a match-type code that names the rule used. Both stay fixed until the next frame begins. A frame that ends before its address is complete is rejected, so the downstream buffer can drop it as a runt.

The control logic is a three-state machine. In `IDLE` it waits for the first start-of-frame. In `GATHER` it counts address bytes. In `DECIDED` it holds the verdict.

Transitions:
- `IDLE`→`GATHER` on start-of-frame.
- `GATHER`→`DECIDED` on the sixth byte, or on an early end-of-frame.
- `GATHER`→`GATHER` on a new start-of-frame.
- `DECIDED`→`GATHER` on start-of-frame.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, `verdict_vld_o`, `accept_o` and `rule_o` are all 0.
- R2: A `sof_i` pulse clears the byte count and the CRC, and drops `verdict_vld_o` in the next cycle. A byte presented in the same cycle as `sof_i` is not counted.
- R3: `verdict_vld_o` rises exactly one cycle after the sixth accepted address byte. It then stays high, with `accept_o` and `rule_o` unchanged, until the next `sof_i`.
- R4: Exact unicast match. The first received byte has group bit 0 (its bit 0), and the six received bytes equal `station_addr_i[47:40]`, `[39:32]`, … `[7:0]` in that order. The result is accept with `rule_o`=1.
- R5: Unicast hash. The address is unicast and not an exact match. The hash index is CRC bits [31:26], taken from a CRC-32 register that starts at all ones, uses the reflected polynomial 0xEDB88320, takes each byte LSB first, and gets no final inversion. If `ucast_hash_i[index]` is 1, the result is accept with `rule_o`=2; otherwise it is reject with `rule_o`=0.
- R6: Group hash. Bit 0 of the first byte is 1 and the address is not all ones. If `mcast_hash_i[index]` is 1 (same index as R5), the result is accept with `rule_o`=3; otherwise it is reject with `rule_o`=0.
- R7: Broadcast. An all-ones destination is accepted with `rule_o`=4 when `bcast_drop_i`=0 and rejected with `rule_o`=0 when `bcast_drop_i`=1. The group hash is never consulted for it.
- R8: With `promisc_i`=1 and a complete address, the result is accept with `rule_o`=5, ahead of every other rule.
- R9: An `eof_i` while fewer than six bytes have been received produces a verdict one cycle later with `accept_o`=0 and `rule_o`=0, even in promiscuous mode.
- R10: `accept_o` is 1 exactly when `rule_o` is nonzero.
- R11: While a verdict is held, further bytes and `eof_i` have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof_i | input | 1 | Start-of-frame pulse; restarts address collection |
| byte_vld_i | input | 1 | Qualifies `byte_i` |
| byte_i | input | 8 | Destination address byte, wire order |
| eof_i | input | 1 | End-of-frame marker |
| station_addr_i | input | 48 | Station address, first wire byte in [47:40] |
| ucast_hash_i | input | 64 | Unicast hash table |
| mcast_hash_i | input | 64 | Group hash table |
| bcast_drop_i | input | 1 | 1 = reject all-ones destination |
| promisc_i | input | 1 | 1 = accept every complete address |
| verdict_vld_o | output | 1 | Verdict valid, held until next `sof_i` |
| accept_o | output | 1 | 1 = keep frame |
| rule_o | output | 3 | Rule code: 0 reject, 1 exact, 2 unicast hash, 3 group hash, 4 broadcast, 5 promiscuous |

## Verification
On every cycle, the assertions check:
- the valid strobe drops after a start-of-frame;
- a held verdict stays frozen;
- the verdict only rises after a byte or an end-of-frame;
- the accept flag always agrees with the rule code.

Which rule wins for a given address, the CRC-derived hash index, the exact cycle of the verdict, runt rejection, and the ignoring of bytes after the verdict can only be shown by the bench. It compares whole frames against a reference model of the filtering rules.

// File: rtl/rx_addr_filter_pkg.sv
package rx_addr_filter_pkg;
    typedef enum logic [2:0] {
        RULE_REJECT  = 3'd0,
        RULE_EXACT   = 3'd1,
        RULE_UC_HASH = 3'd2,
        RULE_MC_HASH = 3'd3,
        RULE_BCAST   = 3'd4,
        RULE_PROMISC = 3'd5
    } rule_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_GATHER  = 2'd1,
        ST_DECIDED = 2'd2
    } flt_state_e;

    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
endpackage

// File: rtl/rxf_crc_byte.sv
module rxf_crc_byte
    import rx_addr_filter_pkg::*;
(
    input  logic [31:0] crc_in,
    input  logic [7:0]  data_in,
    output logic [31:0] crc_out
);
    always_comb begin
        logic [31:0] c;
        c = crc_in;
        for (int i = 0; i < 8; i++) begin
            if (c[0] ^ data_in[i])
                c = (c >> 1) ^ CRC_POLY_REFL;
            else
                c = c >> 1;
        end
        crc_out = c;
    end
endmodule

// File: rtl/rxf_addr_shift.sv
module rxf_addr_shift #(
    parameter int ADDR_BYTES = 6,
    localparam int ADDR_W = 8 * ADDR_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  logic [7:0]        byte_in,
    output logic [ADDR_W-1:0] addr_d
);
    logic [ADDR_W-1:0] addr_q;

    always_comb begin
        if (clear)
            addr_d = '0;
        else if (load)
            addr_d = {addr_q[ADDR_W-9:0], byte_in};
        else
            addr_d = addr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            addr_q <= '0;
        else
            addr_q <= addr_d;
    end
endmodule

// File: rtl/rxf_rule_eval.sv
module rxf_rule_eval
    import rx_addr_filter_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int HASH_BITS  = 6,
    localparam int ADDR_W = 8 * ADDR_BYTES,
    localparam int TBL_N  = 1 << HASH_BITS
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic [HASH_BITS-1:0] hash_idx,
    input  logic [ADDR_W-1:0]    station,
    input  logic [TBL_N-1:0]     uc_tbl,
    input  logic [TBL_N-1:0]     mc_tbl,
    input  logic                 bcast_drop,
    input  logic                 promisc,
    output rule_e                rule
);
    logic is_bcast, is_group, is_exact;

    assign is_bcast = &addr;
    assign is_group = addr[ADDR_W-8];
    assign is_exact = (addr == station);

    always_comb begin
        if (promisc)
            rule = RULE_PROMISC;
        else if (is_bcast)
            rule = bcast_drop ? RULE_REJECT : RULE_BCAST;
        else if (is_group)
            rule = mc_tbl[hash_idx] ? RULE_MC_HASH : RULE_REJECT;
        else if (is_exact)
            rule = RULE_EXACT;
        else
            rule = uc_tbl[hash_idx] ? RULE_UC_HASH : RULE_REJECT;
    end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import rx_addr_filter_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int HASH_BITS  = 6,
    localparam int ADDR_W = 8 * ADDR_BYTES,
    localparam int TBL_N  = 1 << HASH_BITS,
    localparam int CNT_W  = $clog2(ADDR_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sof_i,
    input  logic              byte_vld_i,
    input  logic [7:0]        byte_i,
    input  logic              eof_i,
    input  logic [ADDR_W-1:0] station_addr_i,
    input  logic [TBL_N-1:0]  ucast_hash_i,
    input  logic [TBL_N-1:0]  mcast_hash_i,
    input  logic              bcast_drop_i,
    input  logic              promisc_i,
    output logic              verdict_vld_o,
    output logic              accept_o,
    output logic [2:0]        rule_o
);
    flt_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [31:0]       crc_q, crc_step, crc_d;
    logic [ADDR_W-1:0] addr_d;
    logic              take_byte, last_byte, runt_end;
    rule_e             rule_d;

    assign take_byte = (state_q == ST_GATHER) && byte_vld_i && !sof_i;
    assign last_byte = take_byte && (cnt_q == CNT_W'(ADDR_BYTES - 1));
    assign runt_end  = (state_q == ST_GATHER) && eof_i && !sof_i && !last_byte;

    rxf_crc_byte u_crc (
        .crc_in  (crc_q),
        .data_in (byte_i),
        .crc_out (crc_step)
    );

    assign crc_d = sof_i ? 32'hFFFF_FFFF : (take_byte ? crc_step : crc_q);

    rxf_addr_shift #(.ADDR_BYTES(ADDR_BYTES)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (sof_i),
        .load    (take_byte),
        .byte_in (byte_i),
        .addr_d  (addr_d)
    );

    rxf_rule_eval #(.ADDR_BYTES(ADDR_BYTES), .HASH_BITS(HASH_BITS)) u_eval (
        .addr       (addr_d),
        .hash_idx   (crc_d[31 -: HASH_BITS]),
        .station    (station_addr_i),
        .uc_tbl     (ucast_hash_i),
        .mc_tbl     (mcast_hash_i),
        .bcast_drop (bcast_drop_i),
        .promisc    (promisc_i),
        .rule       (rule_d)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (sof_i) state_d = ST_GATHER;
            ST_GATHER:  if (sof_i) state_d = ST_GATHER;
                        else if (last_byte || runt_end) state_d = ST_DECIDED;
            ST_DECIDED: if (sof_i) state_d = ST_GATHER;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register, byte counter and CRC
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            crc_q   <= 32'hFFFF_FFFF;
        end else begin
            state_q <= state_d;
            crc_q   <= crc_d;
            if (sof_i)
                cnt_q <= '0;
            else if (take_byte)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // registered verdict outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            verdict_vld_o <= 1'b0;
            accept_o      <= 1'b0;
            rule_o        <= RULE_REJECT;
        end else if (sof_i) begin
            verdict_vld_o <= 1'b0;
            accept_o      <= 1'b0;
            rule_o        <= RULE_REJECT;
        end else if (last_byte) begin
            verdict_vld_o <= 1'b1;
            accept_o      <= (rule_d != RULE_REJECT);
            rule_o        <= rule_d;
        end else if (runt_end) begin
            verdict_vld_o <= 1'b1;
            accept_o      <= 1'b0;
            rule_o        <= RULE_REJECT;
        end
    end
endmodule

// File: rtl/rx_addr_filter_chk.sv
module rx_addr_filter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sof_i,
    input logic       byte_vld_i,
    input logic       eof_i,
    input logic       verdict_vld_o,
    input logic       accept_o,
    input logic [2:0] rule_o
);
    p_clear_on_sof_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sof_i |=> !verdict_vld_o);

    p_hold_verdict_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict_vld_o && !sof_i) |=> (verdict_vld_o && $stable(accept_o) && $stable(rule_o)));

    p_rise_has_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(verdict_vld_o) |-> $past(byte_vld_i || eof_i));

    p_accept_matches_rule_r10: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o == (rule_o != 3'd0));

    p_rule_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rule_o <= 3'd5);
endmodule

bind rx_addr_filter rx_addr_filter_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sof_i         (sof_i),
    .byte_vld_i    (byte_vld_i),
    .eof_i         (eof_i),
    .verdict_vld_o (verdict_vld_o),
    .accept_o      (accept_o),
    .rule_o        (rule_o)
);

// File: tb/rx_addr_filter_test.sv
`timescale 1ns/1ps
module rx_addr_filter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sof_i = 1'b0, byte_vld_i = 1'b0, eof_i = 1'b0;
    logic [7:0]  byte_i = '0;
    logic [47:0] station_addr_i = '0;
    logic [63:0] ucast_hash_i = '0, mcast_hash_i = '0;
    logic        bcast_drop_i = 1'b0, promisc_i = 1'b0;
    logic        verdict_vld_o, accept_o;
    logic [2:0]  rule_o;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    rx_addr_filter uut (.*);

    function automatic logic [5:0] hash_of(input logic [47:0] a);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int k = 0; k < 6; k++) begin
            logic [7:0] b = a[47 - 8*k -: 8];
            for (int i = 0; i < 8; i++) begin
                logic fb = c[0] ^ b[i];
                c = {1'b0, c[31:1]};
                if (fb) c = c ^ 32'hEDB88320;
            end
        end
        return c[31:26];
    endfunction

    function automatic logic [2:0] model(input logic [47:0] a);
        logic [5:0] h = hash_of(a);
        if (promisc_i) return 3'd5;
        if (a == '1) return bcast_drop_i ? 3'd0 : 3'd4;
        if (a[40]) return mcast_hash_i[h] ? 3'd3 : 3'd0;
        if (a == station_addr_i) return 3'd1;
        return ucast_hash_i[h] ? 3'd2 : 3'd0;
    endfunction

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_sof();
        @(negedge clk); sof_i = 1'b1; byte_vld_i = 1'b0; eof_i = 1'b0;
        @(negedge clk); sof_i = 1'b0;
    endtask

    // sends n bytes of a; caller is at a negedge with inputs idle
    task automatic send_bytes(input logic [47:0] a, input int n);
        for (int k = 0; k < n; k++) begin
            byte_vld_i = 1'b1; byte_i = a[47 - 8*k -: 8];
            @(negedge clk);
        end
        byte_vld_i = 1'b0;
    endtask

    task automatic run_frame(input logic [47:0] a, input string req);
        logic [2:0] e;
        pulse_sof();
        check({req, " cleared"}, {4'd0, verdict_vld_o}, 5'd0);
        send_bytes(a, 5);
        check({req, " not early"}, {4'd0, verdict_vld_o}, 5'd0);
        e = model(a);
        send_bytes(a << 40, 1);
        check({req, " R3 timing"}, {4'd0, verdict_vld_o}, 5'd1);
        check({req, " rule"}, {1'b0, accept_o, rule_o}, {1'b0, e != 3'd0, e});
    endtask

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [47:0] a;
        logic [5:0]  h;
        void'($urandom(32'd2024));
        station_addr_i = 48'h02_1A_2B_3C_4D_5E;
        #20;
        @(negedge clk);
        check("R1 reset", {2'd0, verdict_vld_o, accept_o, rule_o[0]}, 5'd0);
        check("R1 reset rule", {2'd0, rule_o}, 5'd0);
        rst_n = 1'b1;

        // R4 exact
        ucast_hash_i = '0;
        run_frame(station_addr_i, "R4 exact");
        // R5 unicast hash hit and miss
        a = 48'h00_11_22_33_44_55; h = hash_of(a);
        ucast_hash_i = '0; ucast_hash_i[h] = 1'b1;
        run_frame(a, "R5 uc hit");
        check("R5 code", {2'd0, rule_o}, 5'd2);
        ucast_hash_i[h] = 1'b0;
        run_frame(a, "R5 uc miss");
        // R6 group hash
        a = 48'h01_00_5E_00_00_FB; h = hash_of(a);
        mcast_hash_i = '0; mcast_hash_i[h] = 1'b1; ucast_hash_i = '1;
        run_frame(a, "R6 mc hit");
        check("R6 code", {2'd0, rule_o}, 5'd3);
        mcast_hash_i = '0;
        run_frame(a, "R6 mc miss");
        check("R6 miss code", {2'd0, rule_o}, 5'd0);
        // R7 broadcast
        mcast_hash_i = '1; bcast_drop_i = 1'b1;
        run_frame('1, "R7 bcast drop");
        check("R7 drop code", {2'd0, rule_o}, 5'd0);
        bcast_drop_i = 1'b0; mcast_hash_i = '0;
        run_frame('1, "R7 bcast keep");
        check("R7 keep code", {2'd0, rule_o}, 5'd4);
        // R8 promiscuous over broadcast drop
        promisc_i = 1'b1; bcast_drop_i = 1'b1;
        run_frame('1, "R8 promisc");
        check("R8 code", {2'd0, rule_o}, 5'd5);
        // R11: extra bytes and eof after verdict ignored
        send_bytes(48'h0, 3);
        @(negedge clk); eof_i = 1'b1; @(negedge clk); eof_i = 1'b0;
        check("R11 held", {1'b0, verdict_vld_o, 3'd5}, {1'b0, 1'b1, rule_o});
        check("R10 accept", {4'd0, accept_o}, 5'd1);
        // R9 runt (promisc still on)
        pulse_sof();
        send_bytes(station_addr_i, 3);
        eof_i = 1'b1; @(negedge clk); eof_i = 1'b0;
        check("R9 runt", {1'b0, verdict_vld_o, accept_o, rule_o[1:0]}, 5'b01000);
        check("R9 runt rule", {2'd0, rule_o}, 5'd0);
        send_bytes(station_addr_i, 6);
        check("R11 after runt", {1'b0, verdict_vld_o, accept_o, 2'd0}, 5'b01000);
        // R9 eof with zero bytes
        promisc_i = 1'b0;
        pulse_sof();
        eof_i = 1'b1; @(negedge clk); eof_i = 1'b0;
        check("R9 empty", {2'd0, verdict_vld_o, accept_o, 1'b0}, 5'b00100);
        // R2: byte on sof cycle not counted
        pulse_sof();
        check("R2 cleared", {4'd0, verdict_vld_o}, 5'd0);
        @(negedge clk); sof_i = 1'b1; byte_vld_i = 1'b1; byte_i = 8'hAA;
        @(negedge clk); sof_i = 1'b0; byte_vld_i = 1'b0;
        send_bytes(station_addr_i, 5);
        check("R2 sof byte ignored", {4'd0, verdict_vld_o}, 5'd0);
        send_bytes(station_addr_i << 40, 1);
        check("R2 exact after sof byte", {2'd0, rule_o}, 5'd1);

        // random frames
        for (int n = 0; n < 400; n++) begin
            int sel = $urandom_range(0, 9);
            ucast_hash_i = {$urandom, $urandom};
            mcast_hash_i = {$urandom, $urandom};
            bcast_drop_i = $urandom_range(0, 1);
            promisc_i    = ($urandom_range(0, 7) == 0);
            a = {$urandom, $urandom};
            if (sel < 2) a = station_addr_i;
            else if (sel == 2) a = '1;
            else if (sel < 6) a[40] = 1'b0;
            run_frame(a, "R4-R8 random");
            check("R10 random", {4'd0, accept_o}, {4'd0, rule_o != 3'd0});
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule